// File: doc/BRIEF.md
# Three-Word Branch Decode Unit

This unit sits behind a short instruction queue whose first three entries can be read in the same cycle. When the head entry is a branch, the unit takes the branch as a group of three consecutive words. The first word is the branch control word. The second is a full-width destination or offset. The third is an ALU instruction, and the flags it produces are the ones the branch tests. All three words are consumed together. The ALU word goes out for dispatch in that same cycle, and the pending branch resolves in the next cycle, when the ALU flags come back.

Fetch always continues down the fall-through path, so every branch is predicted not-taken. A taken branch raises a redirect with the new program counter and flushes the one word that was fetched behind it. That word is also not consumed in the redirect cycle. Calls push their fall-through address onto a small return stack, and returns pop their target from that stack. When the head is a branch but the queue does not yet hold all three of its words, the unit stalls.

Top module: `brDecodeUnit`

## Requirements
- R1: Bit 15 of every word is the mode bit: 1 means ALU, 0 means memory/system. A head word is a branch when bit 15 is 0 and bits 14:12 equal 3'b101. A valid head that is not a branch is consumed alone: qPop is 1, and neither aluIssue nor stall is raised.
- R2: When the head is a branch and qValid is not 3'b111, stall is 1, qPop is 0 and aluIssue is 0. The unit waits until all three words are valid.
- R3: When the head is a branch, all three words are valid and bit 15 of the third word is 1, the unit sets qPop to 3 and aluIssue to 1 in the same cycle, with aluWord equal to the third word. This happens whatever the branch later resolves to.
- R4: When the third word has bit 15 equal to 0, illegal is 1 and qPop is 3. aluIssue stays 0 and no redirect follows.
- R5: A branch resolves in the cycle after its words were consumed, using aluFlags as they stand in that cycle. Bit 9 of the control word set means conditional. Bits 6:4 choose the condition: bits 6:5 index aluFlags (0 zero, 1 negative, 2 carry, 3 overflow), and bit 4 set means the condition is that flag being clear. When the branch is taken, redirect and flush are both 1 for that one cycle and redirectPc holds the target.
- R6: An unconditional branch (bit 9 clear) ignores aluFlags and always redirects in its resolve cycle, with the same one-cycle penalty. A conditional branch whose condition fails produces no redirect, and decode carries on in that cycle.
- R7: Bits 8:7 of the control word choose the addressing mode. 00 means the target is word 1. 01 means the address of word 0 plus word 1. 10 means the address of word 0 minus word 1. 11 behaves like 00. Sums wrap modulo 2^16.
- R8: In a redirect cycle the queue head is squashed: qPop is 0, and aluIssue, stall and illegal are all 0.
- R9: Bits 11:10 of the control word give the kind: 00 jump, 01 call, 10 return, 11 jump. A taken call pushes the address of word 0 plus 3. A taken return redirects to the most recently pushed address that has not yet been popped, ignores word 1, and pops that entry.
- R10: The return stack holds 4 entries. A taken call with the stack full raises stackErr for one cycle, leaves the stack unchanged and still redirects. A return whose condition holds while the stack is empty raises stackErr and does not redirect.
- R11: After reset all outputs are 0 and the return stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| qValid | input | 3 | Valid bits of queue positions 0..2, contiguous from position 0 |
| qWord0 | input | 16 | Queue head word |
| qWord1 | input | 16 | Queue position 1 |
| qWord2 | input | 16 | Queue position 2 |
| headPc | input | 16 | Address of the queue head word |
| aluFlags | input | 4 | Flags from the ALU: {overflow, carry, negative, zero} |
| qPop | output | 2 | Number of words consumed this cycle (0, 1 or 3) |
| stall | output | 1 | Branch head waiting for all three of its words |
| aluIssue | output | 1 | Branch ALU word dispatched this cycle |
| aluWord | output | 16 | ALU word being dispatched |
| illegal | output | 1 | Third word of a branch was not an ALU word |
| redirect | output | 1 | Taken branch: load redirectPc |
| redirectPc | output | 16 | New program counter |
| flush | output | 1 | Discard the word fetched behind the branch |
| stackErr | output | 1 | Return stack overflow or underflow |

## Verification
The bench concentrates on the cycle in which one branch resolves while the next head is already on offer. A unit that failed to squash that head would pop words that belong to the wrong path, and a unit that did not decode during a not-taken resolve would lose throughput that the bench would see as a missing pop. Relative targets that wrap past zero in both directions would show a truncated or sign-extended adder as a wrong redirectPc. Calls are driven past the stack depth and returns past empty: an unguarded push would wipe out the oldest link and shift every later return target, and an unguarded pop would redirect to garbage where no redirect is expected. An illegal third word and a conditional return that fails on an empty stack are the cases in which a loose decoder would raise an error or a redirect that should not appear.

// File: rtl/brdec_pkg.sv
package brdec_pkg;
  localparam int FLAG_W    = 4;
  localparam int MODE_BIT  = 15;
  localparam logic [2:0] BR_CLASS = 3'b101;

  typedef enum logic [1:0] {
    KIND_JUMP = 2'd0,
    KIND_CALL = 2'd1,
    KIND_RET  = 2'd2,
    KIND_ALT  = 2'd3
  } brKindT;

  typedef enum logic [1:0] {
    AM_DIRECT = 2'd0,
    AM_FWD    = 2'd1,
    AM_BACK   = 2'd2,
    AM_ALT    = 2'd3
  } addrModeT;

  typedef struct packed {
    logic     isBranch;
    logic     aluLegal;
    brKindT   kind;
    logic     condEn;
    logic [2:0] condSel;
    addrModeT amode;
  } decodeT;

  typedef struct packed {
    logic capture;
    logic push;
    logic pop;
  } ctrlStrobesT;
endpackage

// File: rtl/brDatapath.sv
module brDatapath
  import brdec_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int STACK_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] qWord0,
  input  logic [WORD_W-1:0] qWord1,
  input  logic [WORD_W-1:0] qWord2,
  input  logic [WORD_W-1:0] headPc,
  input  ctrlStrobesT       strobe,
  output decodeT            dec,
  output brKindT            pendKind,
  output logic              pendCondEn,
  output logic [2:0]        pendCondSel,
  output logic              stackEmpty,
  output logic              stackFull,
  output logic [WORD_W-1:0] redirectPc
);
  localparam int CNT_W = $clog2(STACK_DEPTH + 1);

  logic [WORD_W-1:0] newTarget;
  logic [WORD_W-1:0] pendTarget;
  logic [WORD_W-1:0] pendLink;
  logic [WORD_W-1:0] stackTop;
  logic [WORD_W-1:0] slotQ [STACK_DEPTH];
  logic [CNT_W-1:0]  depth;

  // Field decode of the control word and legality of the ALU word
  always_comb begin
    dec.isBranch = !qWord0[MODE_BIT] && (qWord0[14:12] == BR_CLASS);
    dec.aluLegal = qWord2[MODE_BIT];
    dec.kind     = (qWord0[11:10] == 2'b11) ? KIND_JUMP : brKindT'(qWord0[11:10]);
    dec.condEn   = qWord0[9];
    dec.amode    = addrModeT'(qWord0[8:7]);
    dec.condSel  = qWord0[6:4];
  end

  // Target arithmetic, done while the words are in the queue
  always_comb begin
    unique case (dec.amode)
      AM_FWD:  newTarget = headPc + qWord1;
      AM_BACK: newTarget = headPc - qWord1;
      default: newTarget = qWord1;
    endcase
  end

  // Pending branch held for the resolve cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendTarget  <= '0;
      pendLink    <= '0;
      pendKind    <= KIND_JUMP;
      pendCondEn  <= 1'b0;
      pendCondSel <= '0;
    end else if (strobe.capture) begin
      pendTarget  <= newTarget;
      pendLink    <= headPc + WORD_W'(3);
      pendKind    <= dec.kind;
      pendCondEn  <= dec.condEn;
      pendCondSel <= dec.condSel;
    end
  end

  // Return stack: slots addressed by the current depth
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depth <= '0;
      for (int i = 0; i < STACK_DEPTH; i++) slotQ[i] <= '0;
    end else begin
      for (int i = 0; i < STACK_DEPTH; i++)
        if (strobe.push && depth == CNT_W'(i)) slotQ[i] <= pendLink;
      if (strobe.push)     depth <= depth + CNT_W'(1);
      else if (strobe.pop) depth <= depth - CNT_W'(1);
    end
  end

  always_comb begin
    stackTop = '0;
    for (int i = 0; i < STACK_DEPTH; i++)
      if (depth == CNT_W'(i + 1)) stackTop = slotQ[i];
  end

  assign stackEmpty = (depth == '0);
  assign stackFull  = (depth == CNT_W'(STACK_DEPTH));
  assign redirectPc = (pendKind == KIND_RET) ? stackTop : pendTarget;
endmodule

// File: rtl/brCtrl.sv
module brCtrl
  import brdec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        qValid,
  input  decodeT            dec,
  input  brKindT            pendKind,
  input  logic              pendCondEn,
  input  logic [2:0]        pendCondSel,
  input  logic [FLAG_W-1:0] aluFlags,
  input  logic              stackEmpty,
  input  logic              stackFull,
  output ctrlStrobesT       strobe,
  output logic [1:0]        qPop,
  output logic              stall,
  output logic              aluIssue,
  output logic              illegal,
  output logic              redirect,
  output logic              flush,
  output logic              stackErr
);
  logic pendValid;
  logic flagBit;
  logic condMet;
  logic retEmpty;
  logic taken;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendValid <= 1'b0;
    else       pendValid <= strobe.capture;
  end

  // Resolve stage
  always_comb begin
    flagBit  = aluFlags[pendCondSel[2:1]];
    condMet  = !pendCondEn || (flagBit ^ pendCondSel[0]);
    retEmpty = (pendKind == KIND_RET) && stackEmpty;
    taken    = pendValid && condMet && !retEmpty;
    stackErr = pendValid && condMet &&
               (retEmpty || (pendKind == KIND_CALL && stackFull));
    redirect = taken;
    flush    = taken;
  end

  // Decode stage, squashed by a redirect
  always_comb begin
    strobe.push    = taken && (pendKind == KIND_CALL) && !stackFull;
    strobe.pop     = taken && (pendKind == KIND_RET);
    strobe.capture = 1'b0;
    qPop     = 2'd0;
    stall    = 1'b0;
    aluIssue = 1'b0;
    illegal  = 1'b0;
    if (!taken) begin
      if (qValid[0] && dec.isBranch) begin
        if (&qValid) begin
          qPop = 2'd3;
          if (dec.aluLegal) begin
            aluIssue       = 1'b1;
            strobe.capture = 1'b1;
          end else begin
            illegal = 1'b1;
          end
        end else begin
          stall = 1'b1;
        end
      end else if (qValid[0]) begin
        qPop = 2'd1;
      end
    end
  end
endmodule

// File: rtl/brDecodeUnit.sv
module brDecodeUnit
  import brdec_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int STACK_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        qValid,
  input  logic [WORD_W-1:0] qWord0,
  input  logic [WORD_W-1:0] qWord1,
  input  logic [WORD_W-1:0] qWord2,
  input  logic [WORD_W-1:0] headPc,
  input  logic [3:0]        aluFlags,
  output logic [1:0]        qPop,
  output logic              stall,
  output logic              aluIssue,
  output logic [WORD_W-1:0] aluWord,
  output logic              illegal,
  output logic              redirect,
  output logic [WORD_W-1:0] redirectPc,
  output logic              flush,
  output logic              stackErr
);
  ctrlStrobesT strobe;
  decodeT      dec;
  brKindT      pendKind;
  logic        pendCondEn;
  logic [2:0]  pendCondSel;
  logic        stackEmpty;
  logic        stackFull;

  brDatapath #(.WORD_W(WORD_W), .STACK_DEPTH(STACK_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN),
    .qWord0(qWord0), .qWord1(qWord1), .qWord2(qWord2), .headPc(headPc),
    .strobe(strobe), .dec(dec),
    .pendKind(pendKind), .pendCondEn(pendCondEn), .pendCondSel(pendCondSel),
    .stackEmpty(stackEmpty), .stackFull(stackFull), .redirectPc(redirectPc)
  );

  brCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .qValid(qValid), .dec(dec),
    .pendKind(pendKind), .pendCondEn(pendCondEn), .pendCondSel(pendCondSel),
    .aluFlags(aluFlags), .stackEmpty(stackEmpty), .stackFull(stackFull),
    .strobe(strobe), .qPop(qPop), .stall(stall), .aluIssue(aluIssue),
    .illegal(illegal), .redirect(redirect), .flush(flush), .stackErr(stackErr)
  );

  assign aluWord = qWord2;
endmodule

// File: rtl/brDecodeUnit_chk.sv
module brDecodeUnit_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] qValid,
  input logic [1:0] qPop,
  input logic       stall,
  input logic       aluIssue,
  input logic       illegal,
  input logic       redirect,
  input logic       flush,
  input logic       stackErr
);
  assert_pop_code_R1: assert property (@(posedge clk) disable iff (!rstN)
    qPop != 2'd2);

  assert_stall_waits_R2: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (qPop == 2'd0 && !aluIssue && qValid != 3'b111));

  assert_issue_takes_three_R3: assert property (@(posedge clk) disable iff (!rstN)
    aluIssue |-> qPop == 2'd3);

  assert_illegal_no_issue_R4: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!aluIssue && qPop == 2'd3));

  assert_redirect_follows_issue_R5: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> $past(aluIssue));

  assert_redirect_squash_R8: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> (flush && qPop == 2'd0 && !aluIssue && !stall && !illegal));

  assert_no_double_redirect_R8: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> !redirect);

  assert_err_after_issue_R10: assert property (@(posedge clk) disable iff (!rstN)
    stackErr |-> $past(aluIssue));
endmodule

bind brDecodeUnit brDecodeUnit_chk u_chk (.*);

// File: tb/brDecodeUnit_bench.sv
module brDecodeUnit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  qValid = '0;
  logic [15:0] qWord0 = '0, qWord1 = '0, qWord2 = '0, headPc = '0;
  logic [3:0]  aluFlags = '0;
  logic [1:0]  qPop;
  logic        stall, aluIssue, illegal, redirect, flush, stackErr;
  logic [15:0] aluWord, redirectPc;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit          mPend = 0;
  int          mKind = 0;
  bit          mCondEn = 0;
  int          mSel = 0;
  logic [15:0] mTarget = '0, mLink = '0;
  logic [15:0] mStk[$];

  localparam logic [15:0] ALUW = 16'h8A05;
  localparam logic [15:0] OTHER = 16'h1000;

  always #5 clk = ~clk;

  brDecodeUnit u_brDecodeUnit (
    .clk(clk), .rstN(rstN), .qValid(qValid), .qWord0(qWord0), .qWord1(qWord1),
    .qWord2(qWord2), .headPc(headPc), .aluFlags(aluFlags), .qPop(qPop),
    .stall(stall), .aluIssue(aluIssue), .aluWord(aluWord), .illegal(illegal),
    .redirect(redirect), .redirectPc(redirectPc), .flush(flush), .stackErr(stackErr)
  );

  function automatic logic [15:0] mkBr(input int kind, input int sel,
                                       input bit condEn, input int amode);
    return {1'b0, 3'b101, 2'(kind), condEn, 2'(amode), 3'(sel), 4'h0};
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] v, input logic [15:0] w0, input logic [15:0] w1,
                       input logic [15:0] w2, input logic [15:0] pc, input logic [3:0] fl);
    qValid = v; qWord0 = w0; qWord1 = w1; qWord2 = w2; headPc = pc; aluFlags = fl;
  endtask

  task automatic step(input string tag);
    bit flagOk, condMet, under, eTaken, eErr, isBr, eStall, eIssue, eIll;
    int ePop, sz;
    logic [15:0] ePc, t;
    #1;
    sz      = mStk.size();
    flagOk  = aluFlags[mSel / 2] ^ (mSel % 2 == 1);
    condMet = !mCondEn || flagOk;
    under   = (mKind == 2) && (sz == 0);
    eTaken  = mPend && condMet && !under;
    eErr    = mPend && condMet && ((mKind == 1 && sz == 4) || under);
    ePc     = (mKind == 2 && sz > 0) ? mStk[sz-1] : mTarget;
    isBr    = qValid[0] && !qWord0[15] && qWord0[14:12] == 3'b101;
    ePop = 0; eStall = 0; eIssue = 0; eIll = 0;
    if (!eTaken) begin
      if (isBr && qValid == 3'b111) begin
        ePop = 3; eIssue = qWord2[15]; eIll = !qWord2[15];
      end else if (isBr) eStall = 1;
      else if (qValid[0]) ePop = 1;
    end
    check(tag, "qPop", int'(qPop), ePop);
    check(tag, "stall", int'(stall), int'(eStall));
    check(tag, "aluIssue", int'(aluIssue), int'(eIssue));
    check(tag, "illegal", int'(illegal), int'(eIll));
    check(tag, "redirect", int'(redirect), int'(eTaken));
    check(tag, "flush", int'(flush), int'(eTaken));
    check(tag, "stackErr", int'(stackErr), int'(eErr));
    if (eIssue) check(tag, "aluWord", int'(aluWord), int'(qWord2));
    if (eTaken) check(tag, "redirectPc", int'(redirectPc), int'(ePc));
    @(posedge clk);
    if (eTaken && mKind == 1 && sz < 4) mStk.push_back(mLink);
    if (eTaken && mKind == 2) void'(mStk.pop_back());
    mPend = eIssue;
    if (eIssue) begin
      mKind   = (qWord0[11:10] == 2'b11) ? 0 : int'(qWord0[11:10]);
      mCondEn = qWord0[9];
      mSel    = int'(qWord0[6:4]);
      case (qWord0[8:7])
        2'b01:   t = headPc + qWord1;
        2'b10:   t = headPc - qWord1;
        default: t = qWord1;
      endcase
      mTarget = t;
      mLink   = headPc + 16'd3;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11: idle after reset
    drive(3'b000, 0, 0, 0, 0, 0); step("R11");
    // R1: non-branch heads
    drive(3'b001, OTHER, 0, 0, 16'h10, 0); step("R1");
    drive(3'b111, 16'h8123, ALUW, ALUW, 16'h11, 0); step("R1");
    // R2: partial branch waits
    drive(3'b011, mkBr(0, 0, 1, 0), 16'h1234, 0, 16'h100, 0); step("R2");
    drive(3'b001, mkBr(0, 0, 1, 0), 0, 0, 16'h100, 0); step("R2");
    // R3/R5: conditional on zero, taken; next full branch squashed (R8)
    drive(3'b111, mkBr(0, 0, 1, 0), 16'h1234, ALUW, 16'h100, 0); step("R3");
    drive(3'b111, mkBr(0, 0, 1, 0), 16'h5555, ALUW, 16'h103, 4'b0001); step("R8");
    drive(3'b000, 0, 0, 0, 0, 0); step("R8");
    // R6: condition fails, decode continues in resolve cycle
    drive(3'b111, mkBr(0, 0, 1, 0), 16'h2222, ALUW, 16'h200, 0); step("R3");
    drive(3'b001, 16'h8123, 0, 0, 16'h203, 4'b0000); step("R6");
    // R6/R7: unconditional forward with wrap, flags ignored
    drive(3'b111, mkBr(0, 1, 0, 1), 16'h0020, ALUW, 16'hFFF0, 0); step("R7");
    drive(3'b000, 0, 0, 0, 0, 4'b1111); step("R6");
    // R7: backward with wrap, carry set
    drive(3'b111, mkBr(0, 4, 1, 2), 16'h0030, ALUW, 16'h0010, 0); step("R7");
    drive(3'b000, 0, 0, 0, 0, 4'b0100); step("R7");
    // R7: mode 11 acts as direct
    drive(3'b111, mkBr(0, 0, 0, 3), 16'h4444, ALUW, 16'h0300, 0); step("R7");
    drive(3'b000, 0, 0, 0, 0, 0); step("R7");
    // R5: overflow clear (taken), overflow set test (not taken)
    drive(3'b111, mkBr(0, 7, 1, 0), 16'h0700, ALUW, 16'h0400, 0); step("R5");
    drive(3'b000, 0, 0, 0, 0, 4'b0111); step("R5");
    drive(3'b111, mkBr(0, 6, 1, 0), 16'h0800, ALUW, 16'h0410, 0); step("R5");
    drive(3'b000, 0, 0, 0, 0, 4'b0111); step("R5");
    // R5: negative flag clear test while negative set -> not taken
    drive(3'b111, mkBr(0, 3, 1, 1), 16'h0008, ALUW, 16'h0420, 0); step("R5");
    drive(3'b000, 0, 0, 0, 0, 4'b0010); step("R5");
    // R4: illegal third word
    drive(3'b111, mkBr(0, 0, 0, 0), 16'h0900, OTHER, 16'h0500, 0); step("R4");
    drive(3'b000, 0, 0, 0, 0, 0); step("R4");
    // R9/R10: five calls, last overflows
    for (int i = 0; i < 5; i++) begin
      drive(3'b111, mkBr(1, 0, 0, 0), 16'h0300 + 16'(i), ALUW, 16'h0200 + 16'(i*8), 0);
      step("R9");
      drive(3'b000, 0, 0, 0, 0, 0);
      if (i == 4) step("R10"); else step("R9");
    end
    // R9/R10: five returns, last underflows
    for (int i = 0; i < 5; i++) begin
      drive(3'b111, mkBr(2, 0, 0, 0), 16'hDEAD, ALUW, 16'h0600 + 16'(i*4), 0);
      step("R9");
      drive(3'b000, 0, 0, 0, 0, 0);
      if (i == 4) step("R10"); else step("R9");
    end
    // R10: failing conditional return on empty stack: no error
    drive(3'b111, mkBr(2, 0, 1, 0), 0, ALUW, 16'h0700, 0); step("R10");
    drive(3'b000, 0, 0, 0, 0, 4'b0000); step("R10");
    // R6: back-to-back branches, first not taken, second taken
    drive(3'b111, mkBr(0, 2, 1, 0), 16'h0A00, ALUW, 16'h0800, 0); step("R6");
    drive(3'b111, mkBr(0, 2, 1, 1), 16'h0010, ALUW, 16'h0803, 4'b0000); step("R6");
    drive(3'b011, mkBr(0, 0, 0, 0), 0, 0, 16'h0806, 4'b0010); step("R8");
    drive(3'b000, 0, 0, 0, 0, 0); step("R11");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule